// File: doc/BRIEF.md
# Downstream Port Power and Status Controller

This block sits in a full-speed hub and turns the host's per-port power requests into active-low power-switch enables for a parameterised number of downstream ports (seven by default). Each port has an active-low overcurrent input from its external power switch. The input must stay low for a set number of consecutive clock samples before the block accepts it, so short spikes are ignored. Once accepted, the overcurrent removes power and sets a sticky per-port fault flag. Only an explicit clear removes the flag. After the clear, the host has to withdraw its request and raise it again before the port gets power back.

A mode input picks one of two power schemes. In individual mode each port follows its own request and its own overcurrent. In ganged mode every enable moves together: power is on while any port asks for it, and an overcurrent on any input shuts all ports down. The block also drives three indicator levels: hub configured, some port powered, and every port enabled. A common output-enable for the three indicators is dropped during suspend so that the indicator pins float.

Each port has its own four-state machine. The states are:
- PS_OFF: power off, no fault.
- PS_ON: power on.
- PS_TRIP: power off, fault flag set.
- PS_HOLD: power off, flag cleared, waiting for the request to drop.

The transitions are:
- PS_OFF→PS_ON on a request.
- PS_ON→PS_OFF when the request drops.
- PS_OFF/PS_ON/PS_HOLD→PS_TRIP on an accepted overcurrent. Overcurrent takes priority over a request.
- PS_TRIP→PS_HOLD on clear.
- PS_HOLD→PS_OFF when the request is low.

Top module: `hub_dpwr_ctrl`

## Requirements
- R1: While and after reset, every `pwr_en_n` bit is 1 (power off) and every `oc_flag` bit is 0.
- R2: An overcurrent input is accepted only after it has been sampled low on FILT_LEN consecutive rising edges. The affected power is removed on the next edge after that. A shorter low pulse changes no output.
- R3: In individual mode (`gang_mode`=0), port i's `pwr_en_n[i]` goes to 0 one clock after `pwr_req[i]` is sampled 1, and goes back to 1 one clock after `pwr_req[i]` is sampled 0.
- R4: In individual mode, an accepted overcurrent on port i switches off only port i and sets `oc_flag[i]`. Other ports keep their state.
- R5: In ganged mode (`gang_mode`=1), all `pwr_en_n` bits are equal at all times. They are 0 while any `pwr_req` bit is 1, and 1 one clock after all requests are 0.
- R6: In ganged mode, an accepted overcurrent on any input switches off every port and sets every `oc_flag` bit.
- R7: `oc_flag[i]` stays 1 until `oc_clr[i]` is sampled 1, and it falls on that edge. In ganged mode, any set `oc_clr` bit clears all flags.
- R8: After a clear, the port stays off even while its request is held. It returns to off-idle once the request is sampled 0, and powers up on the next request. If the overcurrent is still accepted, the flag sets again one clock after the clear.
- R9: `led_cfg` equals `hub_cfg`.
- R10: `led_pwr` is 1 exactly when at least one `pwr_en_n` bit is 0.
- R11: `led_nodis` is 1 exactly when every `port_ena` bit is 1.
- R12: All three `led_oe` bits are 0 while `suspend` is 1 and 1 otherwise. Bit 0 enables `led_cfg`, bit 1 enables `led_pwr`, and bit 2 enables `led_nodis`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gang_mode | input | 1 | 1 = ganged power, 0 = individual; change only under reset |
| hub_cfg | input | 1 | Hub configured flag |
| suspend | input | 1 | Hub in suspend |
| pwr_req | input | NPORTS | Host power request per port |
| port_ena | input | NPORTS | Port enabled per port |
| oc_clr | input | NPORTS | Clear for the sticky overcurrent flag |
| oc_n | input | NPORTS | Active-low overcurrent from the power switches |
| pwr_en_n | output | NPORTS | Active-low power-switch enable |
| oc_flag | output | NPORTS | Sticky overcurrent flag |
| led_cfg | output | 1 | Hub-configured indicator level |
| led_pwr | output | 1 | Any-port-powered indicator level |
| led_nodis | output | 1 | No-port-disabled indicator level |
| led_oe | output | 3 | Indicator output-enables |

## Verification
A request or a clear shows on `pwr_en_n` and `oc_flag` one clock after the edge that samples it. An overcurrent takes effect FILT_LEN+1 edges after its first low sample. The indicator outputs are combinational and follow their inputs in the same cycle. The bench drives inputs just after a rising edge and moves a behavioural model of the ports on every rising edge. It then compares all outputs against the model at the falling edge, so each result is checked in the very cycle it falls due.

// File: rtl/hub_pwr_pkg.sv
package hub_pwr_pkg;

    // Per-port power state
    typedef enum logic [1:0] {
        PS_OFF  = 2'd0,
        PS_ON   = 2'd1,
        PS_TRIP = 2'd2,
        PS_HOLD = 2'd3
    } pstate_t;

    localparam int LED_COUNT = 3;

endpackage

// File: rtl/hub_oc_filter.sv
module hub_oc_filter #(
    parameter int FILT_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_n,
    output logic oc_seen
);
    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] LIMIT = CW'(FILT_LEN);

    logic [CW-1:0] low_run;

    // Count consecutive low samples, saturating at the limit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (oc_n) begin
            low_run <= '0;
        end else if (low_run != LIMIT) begin
            low_run <= low_run + 1'b1;
        end
    end

    assign oc_seen = (low_run == LIMIT);

    // R2: a released input removes recognition at once
    a_r2_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        oc_n |=> !oc_seen);

    // R2: recognition only ever begins after a low sample
    a_r2_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oc_seen) |-> !$past(oc_n));

endmodule

// File: rtl/hub_gang_sel.sv
module hub_gang_sel #(
    parameter int NPORTS = 7
) (
    input  logic              gang_mode,
    input  logic [NPORTS-1:0] req_in,
    input  logic [NPORTS-1:0] trip_in,
    input  logic [NPORTS-1:0] clr_in,
    output logic [NPORTS-1:0] req_eff,
    output logic [NPORTS-1:0] trip_eff,
    output logic [NPORTS-1:0] clr_eff
);
    logic any_req, any_trip, any_clr;

    always_comb begin
        any_req  = |req_in;
        any_trip = |trip_in;
        any_clr  = |clr_in;
    end

    for (genvar g = 0; g < NPORTS; g++) begin : g_sel
        always_comb begin
            if (gang_mode) begin
                req_eff[g]  = any_req;
                trip_eff[g] = any_trip;
                clr_eff[g]  = any_clr;
            end else begin
                req_eff[g]  = req_in[g];
                trip_eff[g] = trip_in[g];
                clr_eff[g]  = clr_in[g];
            end
        end
    end

endmodule

// File: rtl/hub_port_fsm.sv
module hub_port_fsm
    import hub_pwr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic trip,
    input  logic clr,
    output logic pwr_on,
    output logic oc_flag
);
    pstate_t st, st_nx;

    // Next-state selection; overcurrent wins over a request
    always_comb begin
        st_nx = st;
        unique case (st)
            PS_OFF: begin
                if (trip)      st_nx = PS_TRIP;
                else if (req)  st_nx = PS_ON;
            end
            PS_ON: begin
                if (trip)      st_nx = PS_TRIP;
                else if (!req) st_nx = PS_OFF;
            end
            PS_TRIP: begin
                if (clr)       st_nx = PS_HOLD;
            end
            PS_HOLD: begin
                if (trip)      st_nx = PS_TRIP;
                else if (!req) st_nx = PS_OFF;
            end
            default:           st_nx = PS_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= PS_OFF;
        else        st <= st_nx;
    end

    // Outputs decoded from state
    always_comb begin
        pwr_on  = 1'b0;
        oc_flag = 1'b0;
        unique case (st)
            PS_ON:   pwr_on  = 1'b1;
            PS_TRIP: oc_flag = 1'b1;
            default: ;
        endcase
    end

    // R4: an accepted overcurrent always removes power next cycle
    a_r4_trip_kills: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> !pwr_on);

    // R7: the flag holds until a clear arrives
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_flag && !clr) |=> oc_flag);

    // R8: the cycle after a clear never re-powers the port
    a_r8_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oc_flag) |-> !pwr_on);

endmodule

// File: rtl/hub_led_drive.sv
module hub_led_drive
    import hub_pwr_pkg::*;
#(
    parameter int NPORTS = 7
) (
    input  logic                 hub_cfg,
    input  logic                 suspend,
    input  logic [NPORTS-1:0]    port_ena,
    input  logic [NPORTS-1:0]    pwr_on,
    output logic                 led_cfg,
    output logic                 led_pwr,
    output logic                 led_nodis,
    output logic [LED_COUNT-1:0] led_oe
);
    always_comb begin
        led_cfg   = hub_cfg;
        led_pwr   = |pwr_on;
        led_nodis = &port_ena;
        led_oe    = suspend ? '0 : '1;
    end

endmodule

// File: rtl/hub_dpwr_ctrl.sv
module hub_dpwr_ctrl
    import hub_pwr_pkg::*;
#(
    parameter int NPORTS   = 7,
    parameter int FILT_LEN = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 gang_mode,
    input  logic                 hub_cfg,
    input  logic                 suspend,
    input  logic [NPORTS-1:0]    pwr_req,
    input  logic [NPORTS-1:0]    port_ena,
    input  logic [NPORTS-1:0]    oc_clr,
    input  logic [NPORTS-1:0]    oc_n,
    output logic [NPORTS-1:0]    pwr_en_n,
    output logic [NPORTS-1:0]    oc_flag,
    output logic                 led_cfg,
    output logic                 led_pwr,
    output logic                 led_nodis,
    output logic [LED_COUNT-1:0] led_oe
);
    logic [NPORTS-1:0] oc_seen;
    logic [NPORTS-1:0] req_eff, trip_eff, clr_eff;
    logic [NPORTS-1:0] pwr_on;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        hub_oc_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .oc_n    (oc_n[p]),
            .oc_seen (oc_seen[p])
        );

        hub_port_fsm u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (req_eff[p]),
            .trip    (trip_eff[p]),
            .clr     (clr_eff[p]),
            .pwr_on  (pwr_on[p]),
            .oc_flag (oc_flag[p])
        );
    end

    hub_gang_sel #(.NPORTS(NPORTS)) u_sel (
        .gang_mode (gang_mode),
        .req_in    (pwr_req),
        .trip_in   (oc_seen),
        .clr_in    (oc_clr),
        .req_eff   (req_eff),
        .trip_eff  (trip_eff),
        .clr_eff   (clr_eff)
    );

    hub_led_drive #(.NPORTS(NPORTS)) u_led (
        .hub_cfg   (hub_cfg),
        .suspend   (suspend),
        .port_ena  (port_ena),
        .pwr_on    (pwr_on),
        .led_cfg   (led_cfg),
        .led_pwr   (led_pwr),
        .led_nodis (led_nodis),
        .led_oe    (led_oe)
    );

    assign pwr_en_n = ~pwr_on;

    // R5: ganged ports move in lockstep (mode changes only under reset)
    a_r5_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
        gang_mode |-> (pwr_en_n == '0 || pwr_en_n == '1));

    // R6: in ganged mode a fault flag on one port means flags on all
    a_r6_all_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (gang_mode && |oc_flag) |-> (&oc_flag));

    // R10: the powered indicator agrees with the port machines
    a_r10_led_pwr: assert property (@(posedge clk) disable iff (!rst_n)
        led_pwr == (pwr_en_n != '1));

endmodule

// File: tb/sim_hub_dpwr_ctrl.sv
module sim_hub_dpwr_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 7;
    localparam int FL = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gang = 1'b0, cfg = 1'b0, susp = 1'b0;
    logic [NP-1:0] req = '0, ena = '1, clr = '0, ocn = '1;
    logic [NP-1:0] pwr_en_n, oc_flag;
    logic led_cfg, led_pwr, led_nodis;
    logic [2:0] led_oe;

    hub_dpwr_ctrl #(.NPORTS(NP), .FILT_LEN(FL)) u0 (
        .clk(clk), .rst_n(rst_n), .gang_mode(gang), .hub_cfg(cfg),
        .suspend(susp), .pwr_req(req), .port_ena(ena), .oc_clr(clr),
        .oc_n(ocn), .pwr_en_n(pwr_en_n), .oc_flag(oc_flag),
        .led_cfg(led_cfg), .led_pwr(led_pwr), .led_nodis(led_nodis),
        .led_oe(led_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    string tag = "R1";

    // Reference: 0 idle, 1 powered, 2 faulted, 3 waiting for request drop
    int m_st[NP]  = '{default: 0};
    int m_low[NP] = '{default: 0};

    always @(posedge clk) begin : model
        bit seen[NP];
        bit any_r, any_t, any_c, r, t, c;
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) begin
                m_st[i] = 0;
                m_low[i] = 0;
            end
        end else begin
            any_r = 0; any_t = 0; any_c = 0;
            for (int i = 0; i < NP; i++) begin
                seen[i] = (m_low[i] >= FL);
                any_r |= req[i];
                any_t |= seen[i];
                any_c |= clr[i];
            end
            for (int i = 0; i < NP; i++) begin
                r = gang ? any_r : req[i];
                t = gang ? any_t : seen[i];
                c = gang ? any_c : clr[i];
                if (m_st[i] == 2) begin
                    if (c) m_st[i] = 3;
                end else if (t) begin
                    m_st[i] = 2;
                end else if (m_st[i] == 0) begin
                    if (r) m_st[i] = 1;
                end else if (!r) begin
                    m_st[i] = 0;
                end
                if (ocn[i]) m_low[i] = 0;
                else if (m_low[i] < FL) m_low[i]++;
            end
        end
    end

    always @(negedge clk) begin : chk
        logic [NP-1:0] e_pwr, e_flg;
        for (int i = 0; i < NP; i++) begin
            e_pwr[i] = (m_st[i] != 1);
            e_flg[i] = (m_st[i] == 2);
        end
        n_vec++;
        if (pwr_en_n !== e_pwr) begin
            n_bad++;
            $display("FAIL %s pwr_en_n act=%b exp=%b t=%0t", tag, pwr_en_n, e_pwr, $time);
        end
        if (oc_flag !== e_flg) begin
            n_bad++;
            $display("FAIL %s oc_flag act=%b exp=%b t=%0t", tag, oc_flag, e_flg, $time);
        end
        if (led_cfg !== cfg) begin
            n_bad++;
            $display("FAIL R9 led_cfg act=%b exp=%b", led_cfg, cfg);
        end
        if (led_pwr !== (e_pwr != '1)) begin
            n_bad++;
            $display("FAIL R10 led_pwr act=%b exp=%b", led_pwr, (e_pwr != '1));
        end
        if (led_nodis !== (&ena)) begin
            n_bad++;
            $display("FAIL R11 led_nodis act=%b exp=%b", led_nodis, (&ena));
        end
        if (led_oe !== (susp ? 3'b000 : 3'b111)) begin
            n_bad++;
            $display("FAIL R12 led_oe act=%b exp=%b", led_oe, (susp ? 3'b000 : 3'b111));
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL R1 watchdog act=running exp=finished");
        finish_run();
    end

    initial begin : stim
        // R1: reset state in individual mode
        tag = "R1";
        step(3);
        rst_n = 1'b1;
        step(2);
        // R3: individual requests
        tag = "R3";
        req = 7'b0101010; step(3);
        req = 7'b1111111; step(3);
        req = 7'b0000000; step(2);
        req = 7'b1111111; step(2);
        // R2: a glitch one sample short is ignored
        tag = "R2";
        ocn[2] = 1'b0; step(FL-1);
        ocn[2] = 1'b1; step(3);
        // R4: sustained fault on port 2 only
        tag = "R4";
        ocn[2] = 1'b0; step(FL+3);
        ocn[2] = 1'b1; step(2);
        // R7: flag sticks, then clears
        tag = "R7";
        step(4);
        clr[2] = 1'b1; step(1);
        clr[2] = 1'b0; step(2);
        // R8: held request does not re-power; drop and raise does
        tag = "R8";
        step(3);
        req[2] = 1'b0; step(1);
        req[2] = 1'b1; step(2);
        ocn[4] = 1'b0; step(FL+2);
        clr[4] = 1'b1; step(1);
        clr[4] = 1'b0; step(3);
        ocn[4] = 1'b1; clr[4] = 1'b1; step(1);
        clr[4] = 1'b0; req[4] = 1'b0; step(1);
        req[4] = 1'b1; step(2);
        // R9 .. R12: indicators
        tag = "R9";
        cfg = 1'b1; step(2);
        cfg = 1'b0; step(1);
        tag = "R11";
        ena = 7'b1110111; step(2);
        ena = '1; step(1);
        tag = "R10";
        req = '0; step(2);
        tag = "R12";
        susp = 1'b1; step(2);
        susp = 1'b0; step(1);
        // R5: ganged mode entered under reset
        tag = "R5";
        rst_n = 1'b0; gang = 1'b1; step(2);
        rst_n = 1'b1; step(1);
        req = 7'b0001000; step(3);
        req = 7'b1001000; step(2);
        req[3] = 1'b0; step(2);
        req = '0; step(2);
        req = 7'b0000010; step(2);
        // R6: fault on one input shuts everything
        tag = "R6";
        ocn[5] = 1'b0; step(FL+2);
        ocn[5] = 1'b1; step(2);
        // R7: any clear bit clears all flags in ganged mode
        tag = "R7";
        clr = 7'b0000001; step(1);
        clr = '0; step(2);
        req = '0; step(1);
        req = 7'b0100000; step(3);
        finish_run();
    end

endmodule